// File: doc/BRIEF.md
# Supervisor Reset Pulse Sequencer

This block turns two reset sources into a clean, stretched processor reset. The first source is a flag, already synchronous to the block clock, that is high while the supply sits below its reset threshold. This covers power-up, power-down and brownout. The second source is an active-low manual reset pin that may change at any time. While either source is active, reset is held. Once both are quiet, reset stays asserted for a fixed number of ticks of a clock-enable input. A timeout of 200 ms in the target system becomes a small tick count in simulation.

The block drives reset in both polarities. It also gives a single-cycle marker in the first cycle after reset is released, which downstream chip-enable gating can use to reopen its path. A source that returns during the stretch throws away the partial count, so a fresh full timeout is always needed. The manual pin is handled exactly like a brownout.

There are no data streams here, so every pin is a plain level or strobe with no handshake.

Top module: `sup_reset_seq`

## Requirements
- R1: When supply_low_i is high at a rising clock edge, rst_n_o is low after that edge, and it stays low for as long as supply_low_i stays high.
- R2: The manual pin passes through a two-flop synchroniser. A low level on mr_n_i seen at any rising edge k drives rst_n_o low after edge k+2, and rst_n_o stays low while the pin stays low.
- R3: Once neither source is active, reset stays asserted until TIMEOUT_TICKS cycles with tick_i high have been taken. rst_n_o goes high after the edge that takes the last of those ticks.
- R4: If either source becomes active again before the count completes, the count restarts from zero. A full TIMEOUT_TICKS ticks are then needed after the source clears again.
- R5: rst_o is the inverse of rst_n_o at all times.
- R6: While arst_n is low, rst_n_o is low, rst_o is high and rel_pulse_o is low. The stretch count is cleared, so a full timeout follows the release of arst_n.
- R7: rel_pulse_o is high for exactly one cycle: the first cycle in which rst_n_o is high after being low. It is low in every other cycle.
- R8: While reset is asserted, a cycle with tick_i low never releases reset.
- R9: After release, a source that becomes active asserts reset again with the latency of R1 or R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| tick_i | input | 1 | Clock-enable strobe that paces the stretch count |
| supply_low_i | input | 1 | Synchronous flag, high while the supply is below threshold |
| mr_n_i | input | 1 | Manual reset pin, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| rel_pulse_o | output | 1 | Single-cycle marker of reset release |

## Verification
A per-cycle model, built from the requirements, follows the outputs while the source pulses and quiet gaps are swept from zero up to beyond the timeout. The sweep is repeated with ticks every cycle, every second cycle and every third cycle. Gaps shorter than the timeout show whether a restart truly clears the count. Gaps that are exactly as long as the timeout show whether the release lands on the right edge. Single-cycle manual pulses and supply pulses are compared, which tells the synchroniser latency apart from the direct path. A long run of pseudo-random source and tick activity then mixes both sources, overlapping, with a gated tick.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  // Phase of the reset sequencer
  typedef enum logic [1:0] {
    PH_HOLD    = 2'd0,  // a source is active
    PH_STRETCH = 2'd1,  // sources quiet, counting ticks
    PH_RUN     = 2'd2   // reset released
  } seq_phase_e;

  localparam int unsigned DEF_TIMEOUT_TICKS = 200;
  localparam int unsigned DEF_SYNC_STAGES   = 2;

endpackage

// File: rtl/sup_sync_cell.sv
module sup_sync_cell #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= RESET_VAL;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= RESET_VAL;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sup_src_merge.sv
module sup_src_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] active_i,
  output logic             any_o
);

  always_comb begin
    any_o = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      any_o = any_o | active_i[i];
    end
  end

endmodule

// File: rtl/sup_stretch_timer.sv
module sup_stretch_timer
  import sup_reset_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = DEF_TIMEOUT_TICKS
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic src_active_i,
  output logic rst_active_o,
  output logic rel_pulse_o
);

  localparam int unsigned CW = (TIMEOUT_TICKS < 2) ? 1 : $clog2(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  seq_phase_e phase_q;
  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (src_active_i) begin
        phase_q <= PH_HOLD;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_HOLD: begin
            if (tick_i) begin
              if (cnt_q == LAST) begin
                phase_q <= PH_RUN;
                rel_q   <= 1'b1;
                cnt_q   <= '0;
              end else begin
                phase_q <= PH_STRETCH;
                cnt_q   <= cnt_q + 1'b1;
              end
            end
          end
          PH_STRETCH: begin
            if (tick_i) begin
              if (cnt_q == LAST) begin
                phase_q <= PH_RUN;
                rel_q   <= 1'b1;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          PH_RUN: begin
            cnt_q <= '0;
          end
          default: begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  assign rst_active_o = (phase_q != PH_RUN);
  assign rel_pulse_o  = rel_q;

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
  import sup_reset_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = DEF_TIMEOUT_TICKS,
  parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic supply_low_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic rel_pulse_o
);

  logic       mr_n_sync;
  logic [1:0] src_vec;
  logic       src_active;
  logic       rst_active;

  sup_sync_cell #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_mr_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d_i   (mr_n_i),
    .q_o   (mr_n_sync)
  );

  assign src_vec = {~mr_n_sync, supply_low_i};

  sup_src_merge #(
    .N_SRC(2)
  ) u_merge (
    .active_i(src_vec),
    .any_o   (src_active)
  );

  sup_stretch_timer #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_timer (
    .clk         (clk),
    .arst_n      (arst_n),
    .tick_i      (tick_i),
    .src_active_i(src_active),
    .rst_active_o(rst_active),
    .rel_pulse_o (rel_pulse_o)
  );

  assign rst_n_o = ~rst_active;
  assign rst_o   = rst_active;

endmodule

// File: rtl/sup_reset_seq_chk.sv
module sup_reset_seq_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic arst_n,
  input logic tick_i,
  input logic supply_low_i,
  input logic mr_n_i,
  input logic rst_n_o,
  input logic rst_o,
  input logic rel_pulse_o
);

  localparam int unsigned NEED = SYNC_STAGES + 1;

  int unsigned mr_low_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          mr_low_run <= 0;
    else if (mr_n_i)      mr_low_run <= 0;
    else if (mr_low_run < NEED) mr_low_run <= mr_low_run + 1;
  end

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    supply_low_i |=> !rst_n_o);

  // R2
  manual_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mr_low_run >= NEED) |-> !rst_n_o);

  // R5
  polarity_pair_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o != rst_n_o);

  // R7
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rel_pulse_o |-> $rose(rst_n_o));

  // R7
  rise_has_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> rel_pulse_o);

  // R8
  no_tick_no_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!tick_i && !rst_n_o) |=> !rst_n_o);

endmodule

bind sup_reset_seq sup_reset_seq_chk #(
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .tick_i      (tick_i),
  .supply_low_i(supply_low_i),
  .mr_n_i      (mr_n_i),
  .rst_n_o     (rst_n_o),
  .rst_o       (rst_o),
  .rel_pulse_o (rel_pulse_o)
);

// File: tb/test_sup_reset_seq.sv
module test_sup_reset_seq;

  localparam int unsigned T = 5;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic tick_i = 1'b0;
  logic supply_low_i = 1'b0;
  logic mr_n_i = 1'b1;
  logic rst_n_o, rst_o, rel_pulse_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  int unsigned tick_div = 1;
  int unsigned tick_phase = 0;
  logic        tick_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sup_reset_seq #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) i_sup_reset_seq (
    .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .supply_low_i(supply_low_i),
    .mr_n_i(mr_n_i), .rst_n_o(rst_n_o), .rst_o(rst_o), .rel_pulse_o(rel_pulse_o)
  );

  // Requirement model: two-stage pin delay, tick count since sources quiet
  logic m_s1, m_s2, m_rst, m_rel;
  int unsigned m_cnt;
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_rst <= 1'b1; m_rel <= 1'b0; m_cnt <= 0;
    end else begin
      m_s1 <= mr_n_i;
      m_s2 <= m_s1;
      m_rel <= 1'b0;
      if (supply_low_i || !m_s2) begin
        m_rst <= 1'b1; m_cnt <= 0;
      end else if (m_rst && tick_i) begin
        if (m_cnt + 1 == T) begin
          m_rst <= 1'b0; m_rel <= 1'b1; m_cnt <= 0;
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  // Drive tick per mode at negedge, then compare outputs against model
  task automatic step();
    @(negedge clk);
    cyc++;
    check("R1 R2 R3 R4 R9 rst_n_o", rst_n_o, ~m_rst);
    check("R5 rst_o", rst_o, ~rst_n_o);
    check("R7 rel_pulse_o", rel_pulse_o, m_rel);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (tick_div == 0) tick_i = lfsr[0];
    else begin
      tick_phase = (tick_phase + 1) % tick_div;
      tick_i = (tick_phase == 0);
    end
  endtask

  task automatic run(input int unsigned n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    // R6: state under power-on reset
    repeat (3) @(negedge clk);
    check("R6 rst_n_o in reset", rst_n_o, 1'b0);
    check("R6 rst_o in reset", rst_o, 1'b1);
    check("R6 rel_pulse_o in reset", rel_pulse_o, 1'b0);
    tick_i = 1'b1;
    arst_n = 1'b1;
    // R6/R3: full timeout after power-on, ticking every cycle
    for (int i = 0; i < T - 1; i++) begin
      @(negedge clk); cyc++;
      check("R6 held during first timeout", rst_n_o, 1'b0);
    end
    @(negedge clk); cyc++;
    check("R3 released after T ticks", rst_n_o, 1'b1);
    check("R7 pulse on release", rel_pulse_o, 1'b1);
    @(negedge clk); cyc++;
    check("R7 pulse single cycle", rel_pulse_o, 1'b0);

    // R2: one-cycle manual pulse, asserted after edge k+2
    mr_n_i = 1'b0;
    @(negedge clk); cyc++; mr_n_i = 1'b1;
    check("R2 not yet after edge k", rst_n_o, 1'b1);
    @(negedge clk); cyc++;
    check("R2 not yet after edge k+1", rst_n_o, 1'b1);
    @(negedge clk); cyc++;
    check("R2 asserted after edge k+2", rst_n_o, 1'b0);
    run(T + 4);

    // R8: no ticks, no release
    supply_low_i = 1'b1; run(2); supply_low_i = 1'b0;
    tick_div = 1000; tick_phase = 1;
    run(3 * T);
    check("R8 held without ticks", rst_n_o, 1'b0);
    tick_div = 1;
    run(T + 2);

    // Sweep: pulse length x gap x tick divisor, both sources
    for (int d = 1; d <= 3; d++) begin
      tick_div = d;
      for (int src = 0; src < 2; src++) begin
        for (int len = 1; len <= 3; len++) begin
          for (int gap = 0; gap <= d * T + 2; gap++) begin
            if (src == 0) supply_low_i = 1'b1; else mr_n_i = 1'b0;
            run(len);
            supply_low_i = 1'b0; mr_n_i = 1'b1;
            run(gap);   // R4: reassert inside or at the stretch window
            if (src == 0) mr_n_i = 1'b0; else supply_low_i = 1'b1;
            run(len);
            supply_low_i = 1'b0; mr_n_i = 1'b1;
            run(d * T + 6);
          end
        end
      end
    end

    // Mixed pseudo-random activity with a gated tick
    tick_div = 0;
    for (int i = 0; i < 6000; i++) begin
      supply_low_i = (lfsr[7:4] == 4'h0);
      mr_n_i = !(lfsr[11:8] == 4'h1);
      step();
    end

    // R6: async reset mid-operation clears the count
    supply_low_i = 1'b0; mr_n_i = 1'b1; tick_div = 1;
    run(T + 3);
    @(negedge clk); arst_n = 1'b0;
    #1;
    check("R6 async assert", rst_n_o, 1'b0);
    check("R6 async pulse low", rel_pulse_o, 1'b0);
    @(negedge clk); arst_n = 1'b1;
    run(T + 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule